// File: doc/BRIEF.md
# Banked GPIO Port with Masked Data Writes

This block is a general-purpose I/O port of `NUM_BANKS` banks, each `BANK_W` lines wide (24 lines by default). Software reaches it through a byte-wide register bus made of an address, write data, a write strobe and a combinational read-data return. For every line the block drives a pad output value and a pad output enable, and it samples the pad input level.

Output data is never written as a plain byte. Software first places a value byte at a bank's data address, then writes a mask byte at the next address. Only lines whose mask bit is 1 take the staged value, so a single line can change without a read-modify-write sequence. Each line is also an input or an output, and an output line can drive both ways (push-pull), pull low only (open drain) or pull high only (open source).

A control bit holds the whole port in reset. It is set after reset and must be cleared by software before the port does anything.

Top module: `gpio_bank_port`

Register layout for bank b (b = 0..NUM_BANKS-1): value byte at 2b, mask byte at 2b+1, direction at 8+b, mode select at 16+2b, open-mode enable at 17+2b. The control register is at 32.

## Requirements
- R1: After reset the control register reads 1 in bit 0, and every pad output enable and pad output is 0.
- R2: While control bit 0 is 1, every pad output enable is 0, writes to bank registers have no effect, and every address other than control reads 0.
- R3: A write to address 2b stages a value for bank b and leaves the data unchanged. A write of mask M to address 2b+1 sets each data bit whose bit in M is 1 to the staged value and leaves every other data bit as it was.
- R4: A line whose direction bit (address 8+b, bit n%8 for line n) is 0 has its output enable at 0.
- R5: An output line whose open-mode enable bit (address 17+2b) is 0 drives its enable to 1, and its pad output equals its data bit.
- R6: An output line with open-mode enable 1 and mode select (address 16+2b) 0 enables its output only while its data bit is 0.
- R7: An output line with open-mode enable 1 and mode select 1 enables its output only while its data bit is 1.
- R8: Reading address 2b returns the level of bank b's pad inputs through a two-flop synchroniser. A pad change made just after a clock edge shows on the read after the second rising edge and not after the first.
- R9: The direction, mode-select and open-mode-enable registers read back the byte last written to them.
- R10: Setting control bit 0 again clears every bank register, so after release they read 0 and all enables stay 0.
- R11: Mask addresses, unused addresses and control bits above bit 0 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | BANK_W | Write data byte |
| reg_we | input | 1 | Write strobe |
| reg_rdata | output | BANK_W | Read data for reg_addr (combinational) |
| pad_in | input | NUM_LINES | Pad input levels |
| pad_out | output | NUM_LINES | Pad output values |
| pad_oe | output | NUM_LINES | Pad output enables |

## Verification
The bench gives each of the 24 lines all sixteen combinations of direction, open-mode enable, mode select and data bit. A design that swapped the polarity of open drain and open source, or that let a line configured as an input drive, fails on specific lines. Masked writes are driven with a series of different value and mask bytes, with stage-only writes and with repeated mask writes that reuse the staged value. A design that wrote the value byte straight into the data register, or that cleared the unmasked bits, would show the wrong pad outputs. Walking-one pad patterns are read one edge and two edges after they change, which catches a synchroniser that is too short or missing. The bench also checks that the hold bit blocks writes and wipes the configuration, so a port that kept its state across a re-hold would still drive its pads.

// File: rtl/gpio_bank_port.sv
module gpio_bank_port #(
  parameter int NUM_BANKS = 3,
  parameter int BANK_W    = 8,
  parameter int ADDR_W    = 6,
  localparam int NUM_LINES = NUM_BANKS * BANK_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [BANK_W-1:0]    reg_wdata,
  input  logic                 reg_we,
  output logic [BANK_W-1:0]    reg_rdata,
  input  logic [NUM_LINES-1:0] pad_in,
  output logic [NUM_LINES-1:0] pad_out,
  output logic [NUM_LINES-1:0] pad_oe
);
  localparam int DATA_BASE = 0;
  localparam int DIR_BASE  = 8;
  localparam int MODE_BASE = 16;
  localparam int CTRL_ADDR = 32;

  logic                 hold_q;
  logic [NUM_LINES-1:0] data_q, dir_q, odm_q, ode_q, stage_q;
  logic [NUM_LINES-1:0] sync1_q, sync2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= 1'b1;
      data_q  <= '0;
      dir_q   <= '0;
      odm_q   <= '0;
      ode_q   <= '0;
      stage_q <= '0;
    end else begin
      if (reg_we && reg_addr == ADDR_W'(CTRL_ADDR))
        hold_q <= reg_wdata[0];
      if (hold_q) begin
        data_q  <= '0;
        dir_q   <= '0;
        odm_q   <= '0;
        ode_q   <= '0;
        stage_q <= '0;
      end else if (reg_we) begin
        for (int b = 0; b < NUM_BANKS; b++) begin
          if (reg_addr == ADDR_W'(DATA_BASE + 2*b))
            stage_q[b*BANK_W +: BANK_W] <= reg_wdata;
          if (reg_addr == ADDR_W'(DATA_BASE + 2*b + 1))
            data_q[b*BANK_W +: BANK_W] <=
              (data_q[b*BANK_W +: BANK_W] & ~reg_wdata) |
              (stage_q[b*BANK_W +: BANK_W] & reg_wdata);
          if (reg_addr == ADDR_W'(DIR_BASE + b))
            dir_q[b*BANK_W +: BANK_W] <= reg_wdata;
          if (reg_addr == ADDR_W'(MODE_BASE + 2*b))
            odm_q[b*BANK_W +: BANK_W] <= reg_wdata;
          if (reg_addr == ADDR_W'(MODE_BASE + 2*b + 1))
            ode_q[b*BANK_W +: BANK_W] <= reg_wdata;
        end
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(CTRL_ADDR)) begin
      reg_rdata[0] = hold_q;
    end else if (!hold_q) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (reg_addr == ADDR_W'(DATA_BASE + 2*b))
          reg_rdata = sync2_q[b*BANK_W +: BANK_W];
        if (reg_addr == ADDR_W'(DIR_BASE + b))
          reg_rdata = dir_q[b*BANK_W +: BANK_W];
        if (reg_addr == ADDR_W'(MODE_BASE + 2*b))
          reg_rdata = odm_q[b*BANK_W +: BANK_W];
        if (reg_addr == ADDR_W'(MODE_BASE + 2*b + 1))
          reg_rdata = ode_q[b*BANK_W +: BANK_W];
      end
    end
  end

  wire [NUM_LINES-1:0] may_drive = ~ode_q | (odm_q & data_q) | (~odm_q & ~data_q);

  assign pad_out = hold_q ? '0 : data_q;
  assign pad_oe  = hold_q ? '0 : (dir_q & may_drive);
endmodule

// File: rtl/gpio_bank_port_chk.sv
module gpio_bank_port_chk #(
  parameter int NUM_BANKS = 3,
  parameter int BANK_W    = 8,
  parameter int ADDR_W    = 6,
  localparam int NUM_LINES = NUM_BANKS * BANK_W
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 hold,
  input logic                 we,
  input logic [ADDR_W-1:0]    addr,
  input logic [NUM_LINES-1:0] data,
  input logic [NUM_LINES-1:0] dir,
  input logic [NUM_LINES-1:0] odm,
  input logic [NUM_LINES-1:0] ode,
  input logic [NUM_LINES-1:0] sync1,
  input logic [NUM_LINES-1:0] sync2,
  input logic [NUM_LINES-1:0] pad_oe
);
  localparam int CTRL_ADDR = 32;
  wire is_mask_addr = (int'(addr) < 2*NUM_BANKS) && addr[0];

  assert_hold_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> pad_oe == '0);
  assert_hold_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && $past(hold)) |-> (data == '0 && dir == '0 && odm == '0 && ode == '0));
  assert_mask_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !hold && !is_mask_addr && addr != ADDR_W'(CTRL_ADDR)) |=> $stable(data));
  assert_dir_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & ~dir) == '0);
  assert_push_pull_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !hold |-> ((dir & ~ode) & ~pad_oe) == '0);
  assert_open_drain_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & ode & ~odm & data) == '0);
  assert_open_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & ode & odm & ~data) == '0);
  assert_sync_stage_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sync2 == $past(sync1));
endmodule

bind gpio_bank_port gpio_bank_port_chk #(
  .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .hold(hold_q), .we(reg_we), .addr(reg_addr),
  .data(data_q), .dir(dir_q), .odm(odm_q), .ode(ode_q),
  .sync1(sync1_q), .sync2(sync2_q), .pad_oe(pad_oe)
);

// File: tb/test_gpio_bank_port.sv
module test_gpio_bank_port;
  localparam int NB = 3;
  localparam int BW = 8;
  localparam int NL = NB * BW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [5:0]    reg_addr = '0;
  logic [7:0]    reg_wdata = '0;
  logic          reg_we = 1'b0;
  logic [7:0]    reg_rdata;
  logic [NL-1:0] pad_in = '0;
  logic [NL-1:0] pad_out, pad_oe;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gpio_bank_port i_gpio_bank_port (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [7:0] d);
    @(negedge clk);
    reg_addr = 6'(a); reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(int a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = 6'(a);
    #1 d = reg_rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [7:0] r;
    logic [NL-1:0] m_dir, m_ode, m_odm, m_dat, exp_oe, model;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(32, r); chk("R1 ctrl", r, 8'h01);
    chk("R1 oe", pad_oe, '0);
    chk("R1 out", pad_out, '0);

    // R2 held port ignores writes
    wr(8, 8'hFF); wr(0, 8'hFF); wr(1, 8'hFF); wr(17, 8'hFF);
    chk("R2 oe held", pad_oe, '0);
    pad_in = 24'hA5C3F0;
    repeat (3) @(negedge clk);
    rd(0, r); chk("R2 level read held", r, 8'h00);
    wr(32, 8'h00);
    rd(8, r); chk("R2 dir write ignored", r, 8'h00);
    rd(17, r); chk("R2 enable write ignored", r, 8'h00);
    rd(32, r); chk("R1 ctrl released", r, 8'h00);

    // R9 readback
    for (int b = 0; b < NB; b++) begin
      wr(8 + b, 8'(8'h5A + 17*b));
      wr(16 + 2*b, 8'(8'h3C ^ (b*8'h41)));
      wr(17 + 2*b, 8'(8'hC6 + 29*b));
    end
    for (int b = 0; b < NB; b++) begin
      rd(8 + b, r);      chk("R9 dir", r, 8'(8'h5A + 17*b));
      rd(16 + 2*b, r);   chk("R9 mode", r, 8'(8'h3C ^ (b*8'h41)));
      rd(17 + 2*b, r);   chk("R9 enable", r, 8'(8'hC6 + 29*b));
    end

    // R4..R7 exhaustive per-line combinations
    for (int s = 0; s < 16; s++) begin
      for (int n = 0; n < NL; n++) begin
        int c;
        c = (s + n) % 16;
        m_dir[n] = c[0]; m_ode[n] = c[1]; m_odm[n] = c[2]; m_dat[n] = c[3];
      end
      for (int b = 0; b < NB; b++) begin
        wr(8 + b, m_dir[b*8 +: 8]);
        wr(16 + 2*b, m_odm[b*8 +: 8]);
        wr(17 + 2*b, m_ode[b*8 +: 8]);
        wr(2*b, m_dat[b*8 +: 8]);
        wr(2*b + 1, 8'hFF);
      end
      for (int n = 0; n < NL; n++)
        exp_oe[n] = m_dir[n] && (!m_ode[n] || (m_odm[n] ? m_dat[n] : !m_dat[n]));
      chk("R4 input lines", 32'(pad_oe & ~m_dir), 32'(0));
      chk("R5 push-pull", 32'(pad_oe & m_dir & ~m_ode), 32'(exp_oe & m_dir & ~m_ode));
      chk("R6 open drain", 32'(pad_oe & m_ode & ~m_odm), 32'(exp_oe & m_ode & ~m_odm));
      chk("R7 open source", 32'(pad_oe & m_ode & m_odm), 32'(exp_oe & m_ode & m_odm));
      chk("R5 pad value", 32'(pad_out), 32'(m_dat));
    end

    // R3 masked writes
    model = '0;
    for (int b = 0; b < NB; b++) begin
      wr(8 + b, 8'hFF); wr(17 + 2*b, 8'h00);
      wr(2*b, 8'h00); wr(2*b + 1, 8'hFF);
    end
    chk("R3 cleared", pad_out, model);
    for (int k = 0; k < 8; k++) begin
      for (int b = 0; b < NB; b++) begin
        logic [7:0] v, m;
        v = 8'(k*37 + 11 + b*5);
        m = 8'(k*73 + 5 + b*19);
        wr(2*b, v);
        chk("R3 stage only", pad_out, model);
        wr(2*b + 1, m);
        model[b*8 +: 8] = (model[b*8 +: 8] & ~m) | (v & m);
        chk("R3 masked update", pad_out, model);
        wr(2*b + 1, 8'h81);
        model[b*8 +: 8] = (model[b*8 +: 8] & ~8'h81) | (v & 8'h81);
        chk("R3 reuse staged", pad_out, model);
      end
    end

    // R8 synchroniser latency with walking ones
    pad_in = '0;
    repeat (3) @(negedge clk);
    for (int n = 0; n < NL; n++) begin
      logic [NL-1:0] nv;
      nv = NL'(1) << n;
      pad_in = nv;
      rd(2*(n/8), r); chk("R8 one edge", r, 8'h00);
      rd(2*(n/8), r); chk("R8 two edges", r, nv[(n/8)*8 +: 8]);
      pad_in = '0;
      repeat (2) @(negedge clk);
    end

    // R11 unmapped reads
    rd(1, r);  chk("R11 mask addr", r, 8'h00);
    rd(7, r);  chk("R11 gap", r, 8'h00);
    rd(48, r); chk("R11 high addr", r, 8'h00);
    wr(32, 8'hFE);
    rd(32, r); chk("R11 ctrl upper bits", r, 8'h00);

    // R10 re-hold clears state
    wr(32, 8'h01);
    chk("R10 oe held", pad_oe, '0);
    @(negedge clk);
    wr(32, 8'h00);
    chk("R10 out cleared", pad_out, '0);
    chk("R10 oe cleared", pad_oe, '0);
    for (int b = 0; b < NB; b++) begin
      rd(8 + b, r);    chk("R10 dir", r, 8'h00);
      rd(17 + 2*b, r); chk("R10 enable", r, 8'h00);
    end

    finish_run();
  end
endmodule